// File: doc/BRIEF.md
# Serial Channel DMA Handshake Controller

This block drives the request pins and reads the acknowledge pins that connect one serial channel to an external single-address DMA controller. It has three operating modes. In half-duplex DMA mode one shared request/acknowledge pair serves whichever direction is enabled. In full-duplex DMA mode the shared pair serves receive only, and a second pair serves transmit. In non-DMA mode both request pins become outputs under software control. The second request pin can also be set to act as a Request-to-Send output.

Acknowledge and transfer-complete inputs are asynchronous. Each passes through a two-flop synchronizer. A falling acknowledge edge becomes one single-cycle pop strobe toward the receive FIFO or one push strobe toward the transmit FIFO. A strobe is issued only if the target FIFO can accept it. Requests are registered. Each request anticipates the strobe in flight, so it drops in the cycle after the transfer that empties the receive FIFO or fills the transmit FIFO. The synchronized acknowledge levels are always available for software to read, so the acknowledge pins can serve as plain inputs.

Top module: `dma_hs_ctrl`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, `reqAN` and `reqBN` are high (inactive), `rxPop`, `txPush` and `xferDone` are 0, and `ackAState`/`ackBState` are 1.
- R2: With `mode` = 1 (half-duplex), `rxEnable` = 1 and `rxLevel` ≥ 1, `reqAN` is low one clock after the inputs are applied.
- R3: With `mode` = 1, `txEnable` = 1 and `txLevel` < DEPTH, `reqAN` is low. With `rxEnable` = 0 and `txLevel` = DEPTH, `reqAN` is high.
- R4: With `mode` = 2 (full-duplex), `reqAN` is low only when `rxEnable` = 1 and `rxLevel` ≥ 1, whatever the transmit state is. `reqBN` is low exactly when `txEnable` = 1 and `txLevel` < DEPTH.
- R5: With `mode` = 0 or 3 (non-DMA), `reqAN` equals the inverse of `gpoReqA`, one clock later.
- R6: Outside `mode` = 2, `reqBN` equals the inverse of `rtsReq` when `rtsSel` = 1, and the inverse of `gpoReqB` when `rtsSel` = 0, one clock later.
- R7: In half-duplex mode, each falling edge of `ackAN` produces exactly one single-cycle strobe on the third rising clock edge after the fall. The strobe is `rxPop` if `rxEnable` = 1 and `rxLevel` ≥ 1; otherwise it is `txPush` if `txEnable` = 1 and `txLevel` < DEPTH. Both strobes never occur together.
- R8: In full-duplex mode, a falling edge of `ackAN` yields only `rxPop`, and a falling edge of `ackBN` yields only `txPush`, with the R7 latency.
- R9: No strobe is produced in non-DMA mode, on an empty receive FIFO, or on a full transmit FIFO.
- R10: `ackAState` and `ackBState` show the levels of `ackAN` and `ackBN` two clock edges later, in every mode.
- R11: A request that was asserted only because of one remaining receive character, or one free transmit slot, goes high in the cycle after the strobe that uses it.
- R12: In a DMA mode (1 or 2), a falling edge of `dtcN` produces one single-cycle `xferDone` pulse with the R7 latency. In non-DMA mode it produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0/3 non-DMA, 1 half-duplex DMA, 2 full-duplex DMA |
| rxEnable | input | 1 | Receiver enabled |
| txEnable | input | 1 | Transmitter enabled |
| rxLevel | input | LVL_W | Characters held in receive FIFO |
| txLevel | input | LVL_W | Characters held in transmit FIFO |
| gpoReqA | input | 1 | Software value for shared request pin (1 = drive low) |
| gpoReqB | input | 1 | Software value for transmit request pin (1 = drive low) |
| rtsSel | input | 1 | 1: transmit request pin carries RTS |
| rtsReq | input | 1 | RTS value (1 = drive low) |
| ackAN | input | 1 | Shared acknowledge, active low, asynchronous |
| ackBN | input | 1 | Transmit acknowledge, active low, asynchronous |
| dtcN | input | 1 | Transfer complete, active low, asynchronous |
| reqAN | output | 1 | Shared request / general purpose output, active low |
| reqBN | output | 1 | Transmit request / GPO / RTS, active low |
| ackAState | output | 1 | Synchronized `ackAN` level |
| ackBState | output | 1 | Synchronized `ackBN` level |
| rxPop | output | 1 | Receive FIFO read strobe |
| txPush | output | 1 | Transmit FIFO load strobe |
| xferDone | output | 1 | Transfer-complete pulse |

## Verification
The hardest case to reach is the request being withdrawn at exactly the right moment. The FIFO must hold a single character, or have a single free slot, when an acknowledge fall arrives. Then the request has to rise in the cycle right after the strobe, not one cycle later when the FIFO level catches up. The bench keeps its own model of the FIFO level, which follows the strobes. It loads that level to 1 or to DEPTH−1, drives one acknowledge edge, and samples `reqAN` on the cycle of the strobe and on the cycle after it. Before that, the FIFO is also driven into the empty and full states, to show that an acknowledge there produces no strobe.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_HALF = 2'd1,
    MODE_FULL = 2'd2,
    MODE_RSVD = 2'd3
  } dmaMode_e;

  typedef struct packed {
    logic rxPop;
    logic txPush;
    logic xferDone;
  } strobe_t;

  localparam int SYNC_IDX_ACKA = 0;
  localparam int SYNC_IDX_ACKB = 1;
  localparam int SYNC_IDX_DTC  = 2;
  localparam int SYNC_LINES    = 3;
endpackage

// File: rtl/dma_hs_sync.sv
module dma_hs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '1;
    else       stage[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '1;
      else       stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/dma_hs_ctl.sv
module dma_hs_ctl
  import dma_hs_pkg::*;
#(
  parameter int LINES = SYNC_LINES
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmaMode_e         mode,
  input  logic [LINES-1:0] syncN,
  input  logic             rxAvail,
  input  logic             txRoom,
  output strobe_t          strb
);
  logic [LINES-1:0] prevN;
  logic [LINES-1:0] fall;
  strobe_t          strbNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevN <= '1;
    else       prevN <= syncN;
  end

  assign fall = prevN & ~syncN;

  always_comb begin
    strbNext = '0;
    unique case (mode)
      MODE_HALF: begin
        if (fall[SYNC_IDX_ACKA]) begin
          if (rxAvail)     strbNext.rxPop  = 1'b1;
          else if (txRoom) strbNext.txPush = 1'b1;
        end
        strbNext.xferDone = fall[SYNC_IDX_DTC];
      end
      MODE_FULL: begin
        strbNext.rxPop    = fall[SYNC_IDX_ACKA] & rxAvail;
        strbNext.txPush   = fall[SYNC_IDX_ACKB] & txRoom;
        strbNext.xferDone = fall[SYNC_IDX_DTC];
      end
      default: strbNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strb <= '0;
    else       strb <= strbNext;
  end
endmodule

// File: rtl/dma_hs_dp.sv
module dma_hs_dp
  import dma_hs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dmaMode_e         mode,
  input  logic             rxEnable,
  input  logic             txEnable,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             gpoReqA,
  input  logic             gpoReqB,
  input  logic             rtsSel,
  input  logic             rtsReq,
  input  strobe_t          strb,
  output logic             rxAvail,
  output logic             txRoom,
  output logic             reqAN,
  output logic             reqBN
);
  localparam logic [LVL_W:0] FULL_LVL = (LVL_W + 1)'(DEPTH);

  logic [LVL_W:0] rxExt;
  logic [LVL_W:0] txAfterLvl;
  logic           rxLeft;
  logic           txLeft;
  logic           reqANext;
  logic           reqBNext;
  logic           pinB;

  assign rxExt      = {1'b0, rxLevel};
  assign txAfterLvl = {1'b0, txLevel} + (LVL_W + 1)'(strb.txPush);

  assign rxAvail = rxEnable && (rxLevel != '0);
  assign txRoom  = txEnable && ({1'b0, txLevel} < FULL_LVL);

  // account for a strobe already issued this cycle
  assign rxLeft = rxEnable && (rxExt > (LVL_W + 1)'(strb.rxPop));
  assign txLeft = txEnable && (txAfterLvl < FULL_LVL);

  assign pinB = rtsSel ? rtsReq : gpoReqB;

  always_comb begin
    unique case (mode)
      MODE_HALF: begin
        reqANext = ~(rxLeft | txLeft);
        reqBNext = ~pinB;
      end
      MODE_FULL: begin
        reqANext = ~rxLeft;
        reqBNext = ~txLeft;
      end
      default: begin
        reqANext = ~gpoReqA;
        reqBNext = ~pinB;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAN <= 1'b1;
      reqBN <= 1'b1;
    end else begin
      reqAN <= reqANext;
      reqBN <= reqBNext;
    end
  end
endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LVL_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic             rxEnable,
  input  logic             txEnable,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             gpoReqA,
  input  logic             gpoReqB,
  input  logic             rtsSel,
  input  logic             rtsReq,
  input  logic             ackAN,
  input  logic             ackBN,
  input  logic             dtcN,
  output logic             reqAN,
  output logic             reqBN,
  output logic             ackAState,
  output logic             ackBState,
  output logic             rxPop,
  output logic             txPush,
  output logic             xferDone
);
  dmaMode_e               modeE;
  logic [SYNC_LINES-1:0]  rawN;
  logic [SYNC_LINES-1:0]  syncN;
  logic                   rxAvail;
  logic                   txRoom;
  strobe_t                strb;

  assign modeE = dmaMode_e'(mode);

  assign rawN[SYNC_IDX_ACKA] = ackAN;
  assign rawN[SYNC_IDX_ACKB] = ackBN;
  assign rawN[SYNC_IDX_DTC]  = dtcN;

  dma_hs_sync #(.WIDTH(SYNC_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawN), .syncOut(syncN)
  );

  dma_hs_ctl #(.LINES(SYNC_LINES)) u_ctl (
    .clk(clk), .rstN(rstN), .mode(modeE), .syncN(syncN),
    .rxAvail(rxAvail), .txRoom(txRoom), .strb(strb)
  );

  dma_hs_dp #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .mode(modeE),
    .rxEnable(rxEnable), .txEnable(txEnable),
    .rxLevel(rxLevel), .txLevel(txLevel),
    .gpoReqA(gpoReqA), .gpoReqB(gpoReqB),
    .rtsSel(rtsSel), .rtsReq(rtsReq), .strb(strb),
    .rxAvail(rxAvail), .txRoom(txRoom),
    .reqAN(reqAN), .reqBN(reqBN)
  );

  assign ackAState = syncN[SYNC_IDX_ACKA];
  assign ackBState = syncN[SYNC_IDX_ACKB];
  assign rxPop     = strb.rxPop;
  assign txPush    = strb.txPush;
  assign xferDone  = strb.xferDone;
endmodule

// File: rtl/dma_hs_ctrl_chk.sv
module dma_hs_ctrl_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic [LVL_W-1:0] rxLevel,
  input logic             gpoReqA,
  input logic             gpoReqB,
  input logic             rtsSel,
  input logic             rtsReq,
  input logic             reqAN,
  input logic             reqBN,
  input logic             rxPop,
  input logic             txPush,
  input logic             xferDone
);
  logic pastValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  p_pop_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> !rxPop);
  p_push_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    txPush |=> !txPush);
  p_half_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(mode) == 2'd1) |-> !(rxPop && txPush));
  p_nodma_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && ($past(mode) == 2'd0 || $past(mode) == 2'd3))
      |-> (!rxPop && !txPush && !xferDone));
  p_full_empty_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(mode) == 2'd2 && $past(rxLevel) == '0) |-> reqAN);
  p_gpo_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(mode) == 2'd0) |-> (reqAN == !$past(gpoReqA)));
  p_pinb_follow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(mode) != 2'd2)
      |-> (reqBN == !($past(rtsSel) ? $past(rtsReq) : $past(gpoReqB))));
endmodule

bind dma_hs_ctrl dma_hs_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .rxLevel(rxLevel),
  .gpoReqA(gpoReqA), .gpoReqB(gpoReqB), .rtsSel(rtsSel), .rtsReq(rtsReq),
  .reqAN(reqAN), .reqBN(reqBN), .rxPop(rxPop), .txPush(txPush),
  .xferDone(xferDone)
);

// File: tb/tb_dma_hs_ctrl.sv
`timescale 1ns/1ps
module tb_dma_hs_ctrl;
  localparam int DEPTH = 16;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'd0;
  logic rxEn = 1'b0, txEn = 1'b0;
  logic gpoA = 1'b0, gpoB = 1'b0, rtsSel = 1'b0, rtsReq = 1'b0;
  logic ackAN = 1'b1, ackBN = 1'b1, dtcN = 1'b1;
  logic [LVL_W-1:0] rxCnt, txCnt, ldRx, ldTx;
  logic ldFifo = 1'b0;
  logic reqAN, reqBN, ackAState, ackBState, rxPop, txPush, xferDone;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dma_hs_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .mode(modeSel), .rxEnable(rxEn), .txEnable(txEn),
    .rxLevel(rxCnt), .txLevel(txCnt), .gpoReqA(gpoA), .gpoReqB(gpoB),
    .rtsSel(rtsSel), .rtsReq(rtsReq), .ackAN(ackAN), .ackBN(ackBN),
    .dtcN(dtcN), .reqAN(reqAN), .reqBN(reqBN), .ackAState(ackAState),
    .ackBState(ackBState), .rxPop(rxPop), .txPush(txPush), .xferDone(xferDone)
  );

  // FIFO level model following the strobes
  always @(posedge clk) begin
    if (ldFifo) begin
      rxCnt <= ldRx;
      txCnt <= ldTx;
    end else begin
      if (rxPop)  rxCnt <= rxCnt - 1'b1;
      if (txPush) txCnt <= txCnt + 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setFifo(input int rx, input int tx);
    @(negedge clk);
    ldRx = LVL_W'(rx);
    ldTx = LVL_W'(tx);
    ldFifo = 1'b1;
    @(negedge clk);
    ldFifo = 1'b0;
    @(negedge clk);
  endtask

  // which: 0 ackAN, 1 ackBN, 2 dtcN
  task automatic pulse(input int which, output int pops, output int pushes,
                       output int dones);
    pops = 0; pushes = 0; dones = 0;
    @(negedge clk);
    if (which == 0) ackAN = 1'b0;
    else if (which == 1) ackBN = 1'b0;
    else dtcN = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pops += int'(rxPop);
      pushes += int'(txPush);
      dones += int'(xferDone);
    end
    ackAN = 1'b1; ackBN = 1'b1; dtcN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    ldRx = '0; ldTx = '0; ldFifo = 1'b1;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reqAN in reset", int'(reqAN), 1);
    check("R1 reqBN in reset", int'(reqBN), 1);
    rstN = 1'b1;
    @(negedge clk);
    ldFifo = 1'b0;
    check("R1 reqAN after reset", int'(reqAN), 1);
    check("R1 strobes after reset", int'(rxPop) + int'(txPush) + int'(xferDone), 0);
    check("R1 ack levels", int'(ackAState) + int'(ackBState), 2);
  endtask

  task automatic t_nondma();
    int p, q, d;
    modeSel = 2'd0;
    gpoA = 1'b1; @(negedge clk);
    check("R5 gpoA=1", int'(reqAN), 0);
    gpoA = 1'b0; @(negedge clk);
    check("R5 gpoA=0", int'(reqAN), 1);
    modeSel = 2'd3; gpoA = 1'b1; @(negedge clk);
    check("R5 mode3 gpoA=1", int'(reqAN), 0);
    gpoA = 1'b0; modeSel = 2'd0;
    rtsSel = 1'b0; gpoB = 1'b1; rtsReq = 1'b0; @(negedge clk);
    check("R6 gpoB drives", int'(reqBN), 0);
    rtsSel = 1'b1; @(negedge clk);
    check("R6 rts off", int'(reqBN), 1);
    rtsReq = 1'b1; gpoB = 1'b0; modeSel = 2'd1; @(negedge clk);
    check("R6 rts on half", int'(reqBN), 0);
    rtsReq = 1'b0; rtsSel = 1'b0; modeSel = 2'd0;
    ackAN = 1'b0; ackBN = 1'b1;
    repeat (2) @(negedge clk);
    check("R10 ackA low", int'(ackAState), 0);
    check("R10 ackB high", int'(ackBState), 1);
    ackAN = 1'b1; ackBN = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 ackA high", int'(ackAState), 1);
    check("R10 ackB low", int'(ackBState), 0);
    ackBN = 1'b1;
    repeat (3) @(negedge clk);
    rxEn = 1'b1; txEn = 1'b1;
    setFifo(3, 0);
    pulse(0, p, q, d);
    check("R9 nondma no pop", p + q, 0);
    pulse(2, p, q, d);
    check("R12 nondma no done", d, 0);
  endtask

  task automatic t_half_rx();
    int p, q, d;
    modeSel = 2'd1; rxEn = 1'b1; txEn = 1'b0;
    setFifo(2, DEPTH);
    check("R2 half rx req", int'(reqAN), 0);
    pulse(0, p, q, d);
    check("R7 one pop", p, 1);
    check("R7 no push", q, 0);
    check("R2 still req at 1", int'(reqAN), 0);
    // exact-cycle withdrawal with one char left
    @(negedge clk) ackAN = 1'b0;
    repeat (3) @(negedge clk);
    check("R7 pop on third edge", int'(rxPop), 1);
    check("R11 req held during pop", int'(reqAN), 0);
    @(negedge clk);
    check("R7 pop single cycle", int'(rxPop), 0);
    check("R11 req withdrawn", int'(reqAN), 1);
    ackAN = 1'b1;
    repeat (4) @(negedge clk);
    pulse(0, p, q, d);
    check("R9 empty no pop", p + q, 0);
  endtask

  task automatic t_half_tx();
    int p, q, d;
    modeSel = 2'd1; rxEn = 1'b0; txEn = 1'b1;
    setFifo(0, DEPTH);
    check("R3 full no req", int'(reqAN), 1);
    setFifo(0, DEPTH - 1);
    check("R3 half tx req", int'(reqAN), 0);
    pulse(0, p, q, d);
    check("R7 one push", q, 1);
    check("R11 tx req withdrawn", int'(reqAN), 1);
    pulse(0, p, q, d);
    check("R9 full no push", p + q, 0);
    // both enabled, receive served first
    rxEn = 1'b1;
    setFifo(1, 0);
    pulse(0, p, q, d);
    check("R7 rx priority pop", p, 1);
    check("R7 rx priority push", q, 0);
  endtask

  task automatic t_full();
    int p, q, d;
    modeSel = 2'd2; rxEn = 1'b1; txEn = 1'b1;
    setFifo(0, 0);
    check("R4 full reqA rx empty", int'(reqAN), 1);
    check("R4 full reqB room", int'(reqBN), 0);
    pulse(0, p, q, d);
    check("R9 full-mode empty pop", p + q, 0);
    setFifo(1, DEPTH);
    check("R4 full reqA rx data", int'(reqAN), 0);
    check("R4 full reqB full", int'(reqBN), 1);
    pulse(1, p, q, d);
    check("R9 full-mode full push", p + q, 0);
    pulse(0, p, q, d);
    check("R8 ackA pops", p, 1);
    check("R8 ackA no push", q, 0);
    setFifo(0, 3);
    pulse(1, p, q, d);
    check("R8 ackB pushes", q, 1);
    check("R8 ackB no pop", p, 0);
    pulse(2, p, q, d);
    check("R12 done pulse", d, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_nondma();
    t_half_rx();
    t_half_tx();
    t_full();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule